// File: doc/BRIEF.md
# Display-Transmitter Control Target on I2C

This block is a two-wire serial target that stands in for the control port of a display transmitter. A host reaches it at a fixed 7-bit bus address. It reads and writes a small byte-addressed register space through a pointer. In a write transaction the first data byte sets the pointer. Every data byte that follows, in either direction, advances the pointer by one. The clock and data lines are oversampled with the system clock. START and STOP conditions are found from the sampled levels. The block drives the data line only by pulling it low.

The block returns a fixed identity byte and a fixed "sink attached, nothing pending" status. It acknowledges all other writes and discards them. The system-control register is the exception. Through it the host first raises a request for the display data channel and then confirms the grant. When both steps are done, the block asserts a mode output so that the surrounding logic can hand the bus to a separate EDID responder. Clearing the request bit returns the block to normal mode.

Top module: `hdmi_ctl_i2c_target`

## Requirements
- R1: The target acknowledges (pulls SDA low in the ninth clock) a first byte whose upper seven bits equal parameter TGT_ADDR (default 0x39). Bit 0 of that byte is the direction, 1 meaning read. It acknowledges every byte written to it. It never drives SDA for any other address, and such a transaction changes no state.
- R2: In a write transaction, the first byte after the address byte loads the register pointer and is not written to any register.
- R3: The pointer increments by one, modulo 256, after every data byte that is written to a register or read out.
- R4: A write to register 0x1A with bit 2 (request) and bit 1 (grant) both set makes ddc_mode_o go to 1 and records a pending request.
- R5: A write to 0x1A with bit 2 set and bit 1 clear records a pending request and leaves ddc_mode_o unchanged.
- R6: A write to 0x1A with bit 2 clear clears both the pending request and ddc_mode_o.
- R7: Reading 0x1A returns 0x06 while a request is pending and 0x00 otherwise.
- R8: Reading 0x1B returns 0xB0, reading 0x3D returns 0x04, and reading any other register returns 0x00. Writes to registers other than 0x1A have no effect.
- R9: A repeated START for a read does not reload the pointer, so the read goes on from the current pointer. A STOP leaves the pointer unchanged.
- R10: Reset sets the pointer to 0x00, clears the pending request and ddc_mode_o, and releases SDA.
- R11: When the host does not acknowledge a byte it has read, the target releases SDA and ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level, as seen on the wired bus |
| sda_pull_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| ddc_mode_o | output | 1 | 1 while the data channel is handed over |

## Verification
Some rules are checked by assertions on every cycle. The target changes SDA only while SCL is low. The mode flag is never set without a pending request. The pointer moves only on a pointer load or a completed data byte, and a load takes the received byte. A STOP releases the line. A request-clearing write drops both flags. The bench scenarios cover what the assertions cannot see: the read values the host gets, the address match and NACK at the ports, the request and grant sequences, the pointer running on across a repeated START and across a reset, and the pointer byte never acting as register data.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  localparam logic [BYTE_W-1:0] REG_SYSCTL   = 8'h1A;
  localparam logic [BYTE_W-1:0] REG_IDENT    = 8'h1B;
  localparam logic [BYTE_W-1:0] REG_IRQ_EN   = 8'h3C;
  localparam logic [BYTE_W-1:0] REG_IRQ_STAT = 8'h3D;

  localparam int SC_PWRDN_BIT = 4;
  localparam int SC_MUTE_BIT  = 3;
  localparam int SC_REQ_BIT   = 2;
  localparam int SC_GRANT_BIT = 1;
  localparam int SC_HDMI_BIT  = 0;

  localparam logic [BYTE_W-1:0] IDENT_VAL   = 8'hB0;
  localparam logic [BYTE_W-1:0] PLUGGED_VAL = 8'h04;
  localparam logic [BYTE_W-1:0] REQ_ECHO    = 8'h06;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_WRITE, PH_READ} phase_t;

  function automatic logic [BYTE_W-1:0] read_value(input logic [BYTE_W-1:0] ptr,
                                                   input logic req);
    if (ptr == REG_SYSCTL)   return req ? REQ_ECHO : '0;
    if (ptr == REG_IDENT)    return IDENT_VAL;
    if (ptr == REG_IRQ_STAT) return PLUGGED_VAL;
    return '0;
  endfunction

  function automatic logic [BYTE_W-1:0] next_ptr(input logic [BYTE_W-1:0] ptr);
    return ptr + 1'b1;
  endfunction

  function automatic logic drive_low(input phase_t ph, input logic [CNT_W-1:0] cnt,
                                     input logic [BYTE_W-1:0] tx);
    if (ph == PH_READ)
      return (cnt < 4'd8) ? ~tx[3'd7 - cnt[2:0]] : 1'b0;
    if (ph == PH_ADDR || ph == PH_WRITE)
      return cnt == 4'd8;
    return 1'b0;
  endfunction
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end

  assign scl_lvl  = scl_ff[STAGES-1];
  assign sda_lvl  = sda_ff[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2ct_byte_engine.sv
module i2ct_byte_engine
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_low,
  output logic              ptr_load,
  output logic              wr_stb,
  output logic              rd_done,
  output logic [BYTE_W-1:0] byte_q
);
  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, txb, shift_in;
  logic              rw_q, ptr_phase;

  assign shift_in = {shreg[BYTE_W-2:0], sda_lvl};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= PH_IDLE; cnt <= '0; shreg <= '0; txb <= '0;
      rw_q <= 1'b0; ptr_phase <= 1'b0; sda_low <= 1'b0;
      ptr_load <= 1'b0; wr_stb <= 1'b0; rd_done <= 1'b0; byte_q <= '0;
    end else begin
      ptr_load <= 1'b0;
      wr_stb   <= 1'b0;
      rd_done  <= 1'b0;
      if (start_ev) begin
        phase <= PH_ADDR; cnt <= '0; sda_low <= 1'b0;
      end else if (stop_ev) begin
        phase <= PH_IDLE; cnt <= '0; sda_low <= 1'b0;
      end else if (scl_rise) begin
        unique case (phase)
          PH_ADDR: begin
            if (cnt < 4'd8) begin
              shreg <= shift_in;
              if (cnt == 4'd7) begin
                if (shift_in[7:1] == TGT_ADDR) begin
                  cnt  <= 4'd8;
                  rw_q <= shift_in[0];
                end else begin
                  phase <= PH_IDLE;
                end
              end else cnt <= cnt + 1'b1;
            end else begin
              cnt <= '0;
              if (rw_q) begin
                phase <= PH_READ;
                txb   <= rd_data;
              end else begin
                phase     <= PH_WRITE;
                ptr_phase <= 1'b1;
              end
            end
          end
          PH_WRITE: begin
            if (cnt < 4'd8) begin
              shreg <= shift_in;
              if (cnt == 4'd7) begin
                byte_q <= shift_in;
                cnt    <= 4'd8;
                if (ptr_phase) begin
                  ptr_load  <= 1'b1;
                  ptr_phase <= 1'b0;
                end else wr_stb <= 1'b1;
              end else cnt <= cnt + 1'b1;
            end else cnt <= '0;
          end
          PH_READ: begin
            if (cnt < 4'd8) begin
              if (cnt == 4'd7) begin
                rd_done <= 1'b1;
                cnt     <= 4'd8;
              end else cnt <= cnt + 1'b1;
            end else if (sda_lvl) begin
              phase <= PH_IDLE;
            end else begin
              cnt <= '0;
              txb <= rd_data;
            end
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        sda_low <= drive_low(phase, cnt, txb);
      end
    end
endmodule

// File: rtl/i2ct_ctl_regs.sv
module i2ct_ctl_regs
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic              wr_stb,
  input  logic              rd_done,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] ptr_q,
  output logic              ddc_req,
  output logic              ddc_mode
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptr_q <= '0; ddc_req <= 1'b0; ddc_mode <= 1'b0;
    end else begin
      if (ptr_load) ptr_q <= byte_in;
      else if (wr_stb || rd_done) ptr_q <= next_ptr(ptr_q);
      if (wr_stb && ptr_q == REG_SYSCTL) begin
        if (byte_in[SC_REQ_BIT]) begin
          ddc_req <= 1'b1;
          if (byte_in[SC_GRANT_BIT]) ddc_mode <= 1'b1;
        end else begin
          ddc_req  <= 1'b0;
          ddc_mode <= 1'b0;
        end
      end
    end

  assign rd_data = read_value(ptr_q, ddc_req);
endmodule

// File: rtl/hdmi_ctl_i2c_target.sv
module hdmi_ctl_i2c_target
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h39,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_low_o,
  output logic ddc_mode_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic ptr_load, wr_stb, rd_done, ddc_req;
  logic [BYTE_W-1:0] byte_q, rd_data, ptr_q;

  i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i, .scl_lvl, .sda_lvl,
    .scl_rise, .scl_fall, .start_ev, .stop_ev
  );

  i2ct_byte_engine #(.TGT_ADDR(TGT_ADDR)) u_eng (
    .clk, .rst_n, .scl_rise, .scl_fall, .sda_lvl, .start_ev, .stop_ev,
    .rd_data, .sda_low(sda_pull_low_o), .ptr_load, .wr_stb, .rd_done, .byte_q
  );

  i2ct_ctl_regs u_regs (
    .clk, .rst_n, .ptr_load, .wr_stb, .rd_done, .byte_in(byte_q),
    .rd_data, .ptr_q, .ddc_req, .ddc_mode(ddc_mode_o)
  );
endmodule

// File: rtl/hdmi_ctl_i2c_target_chk.sv
module hdmi_ctl_i2c_target_chk
  import i2ct_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              sda_low,
  input logic              stop_ev,
  input logic              ptr_load,
  input logic              wr_stb,
  input logic              rd_done,
  input logic [BYTE_W-1:0] byte_q,
  input logic [BYTE_W-1:0] ptr_q,
  input logic              ddc_req,
  input logic              ddc_mode
);
  p_sda_moves_low_scl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_low != $past(sda_low)) |-> !scl_lvl);

  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> ptr_q == $past(byte_q));

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_done) |=> ptr_q == $past(ptr_q) + 8'd1);

  p_grant_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ddc_mode |-> ddc_req);

  p_req_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ptr_q == REG_SYSCTL && !byte_q[SC_REQ_BIT]) |=> (!ddc_mode && !ddc_req));

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ptr_load || wr_stb || rd_done) |=> ptr_q == $past(ptr_q));

  p_reset_state_r10: assert property (@(posedge clk)
    !rst_n |=> (ptr_q == '0 && !ddc_mode && !ddc_req && !sda_low));

  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_low);
endmodule

bind hdmi_ctl_i2c_target hdmi_ctl_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_low(sda_pull_low_o),
  .stop_ev(stop_ev), .ptr_load(ptr_load), .wr_stb(wr_stb), .rd_done(rd_done),
  .byte_q(byte_q), .ptr_q(ptr_q), .ddc_req(ddc_req), .ddc_mode(ddc_mode_o)
);

// File: tb/sim_hdmi_ctl_i2c_target.sv
`timescale 1ns/1ps
module sim_hdmi_ctl_i2c_target;
  localparam logic [6:0] TGT = 7'h39;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_low, ddc_mode;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_low;

  hdmi_ctl_i2c_target #(.TGT_ADDR(TGT)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_pull_low_o(sda_low), .ddc_mode_o(ddc_mode)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] e_ptr = 8'h00;
  logic e_req = 1'b0, e_mode = 1'b0;
  logic [7:0] wbuf [16];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] p, input logic req);
    case (p)
      8'h1A:   return req ? 8'h06 : 8'h00;
      8'h1B:   return 8'hB0;
      8'h3D:   return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] d);
    if (e_ptr == 8'h1A) begin
      if (d[2]) begin
        e_req = 1'b1;
        if (d[1]) e_mode = 1'b1;
      end else begin
        e_req = 1'b0;
        e_mode = 1'b0;
      end
    end
    e_ptr = e_ptr + 8'd1;
  endtask

  task automatic qw;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    m_sda = 1; qw; m_scl = 1; qw; m_sda = 0; qw; m_scl = 0; qw;
  endtask

  task automatic bus_stop;
    m_sda = 0; qw; m_scl = 1; qw; m_sda = 1; qw;
  endtask

  task automatic wbit(input logic b);
    m_sda = b; qw; m_scl = 1; qw; qw; m_scl = 0; qw;
  endtask

  task automatic rbit(output logic b);
    m_sda = 1; qw; m_scl = 1; qw; b = sda_bus; qw; m_scl = 0; qw;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~ack);
  endtask

  // write transaction: wbuf[0] is the pointer byte, then n-1 data bytes
  task automatic wr_txn(input logic [6:0] a, input int n, input bit keep);
    logic ack;
    bus_start;
    wbyte({a, 1'b0}, ack);
    chk((a == TGT) ? "R1 address ack" : "R1 foreign address nack", ack, (a == TGT));
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], ack);
      if (a == TGT) begin
        chk("R1 write byte ack", ack, 1);
        if (i == 0) e_ptr = wbuf[0];
        else model_write(wbuf[i]);
      end else chk("R1 foreign byte not driven", ack, 0);
    end
    if (!keep) bus_stop;
  endtask

  task automatic rd_txn(input int n, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start;
    wbyte({TGT, 1'b1}, ack);
    chk("R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i < n - 1, d);
      chk(tag, d, exp_read(e_ptr, e_req));
      e_ptr = e_ptr + 8'd1;
    end
    chk("R11 release after host nack", sda_low, 0);
    bus_stop;
  endtask

  task automatic sysctl_write(input logic [7:0] d, input string tag);
    wbuf[0] = 8'h1A; wbuf[1] = d;
    wr_txn(TGT, 2, 0);
    chk(tag, ddc_mode, e_mode);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    qw;
    chk("R10 sda released after reset", sda_low, 0);
    chk("R10 mode clear after reset", ddc_mode, 0);

    // R10/R3/R8: read 30 bytes from the reset pointer, 0x1B must appear at index 27
    rd_txn(30, "R10 R3 R8 read from reset pointer");

    // R5 request only, R7 echo
    sysctl_write(8'h04, "R5 request without grant keeps mode");
    wbuf[0] = 8'h1A; wr_txn(TGT, 1, 1);
    rd_txn(1, "R7 R9 request echo after repeated start");
    sysctl_write(8'h06, "R4 request with grant enters mode");
    sysctl_write(8'h04, "R5 request alone leaves mode set");
    // R2: pointer byte 0x1A (bit 2 clear) must not act as data
    wbuf[0] = 8'h19; wbuf[1] = 8'h00; wr_txn(TGT, 2, 0);
    wbuf[0] = 8'h1A; wr_txn(TGT, 1, 0);
    chk("R2 pointer byte not stored", ddc_mode, 1);
    rd_txn(1, "R9 R7 read after stop keeps pointer");
    sysctl_write(8'h10, "R6 request clear drops mode");
    rd_txn(1, "R7 echo after clear");

    // R3: multi-byte write crossing into 0x1A
    wbuf[0] = 8'h18; wbuf[1] = 8'h55; wbuf[2] = 8'hFF; wbuf[3] = 8'h06;
    wr_txn(TGT, 4, 1);
    chk("R3 third data byte reached 0x1A", ddc_mode, 1);
    rd_txn(3, "R9 R8 read continues at 0x1B");

    // R8: writes to other registers ignored
    wbuf[0] = 8'h3D; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF; wr_txn(TGT, 3, 0);
    wbuf[0] = 8'h1B; wr_txn(TGT, 1, 1);
    rd_txn(1, "R8 identity unchanged by writes");
    wbuf[0] = 8'h3C; wr_txn(TGT, 1, 1);
    rd_txn(2, "R8 enable reads zero, status reads plugged");

    // R1: foreign address must not change state
    wbuf[0] = 8'h1A; wbuf[1] = 8'h00; wr_txn(7'h3B, 2, 0);
    chk("R1 foreign write ignored", ddc_mode, e_mode);
    wbuf[0] = 8'h1A; wr_txn(TGT, 1, 1);
    rd_txn(1, "R1 request survives foreign write");

    // random mix
    for (int t = 0; t < 40; t++) begin
      int k, n;
      logic [7:0] p;
      k = $urandom % 6;
      p = (k == 0) ? 8'h19 : (k == 1) ? 8'h1A : (k == 2) ? 8'h1B :
          (k == 3) ? 8'h3C : (k == 4) ? 8'h3D : 8'($urandom);
      n = 1 + $urandom % 3;
      if ($urandom % 2 == 0) begin
        wbuf[0] = p;
        for (int i = 1; i <= n; i++) begin
          k = $urandom % 4;
          wbuf[i] = (k == 0) ? 8'h00 : (k == 1) ? 8'h04 : (k == 2) ? 8'h06 : 8'($urandom);
        end
        wr_txn(TGT, n + 1, 0);
        chk("R4 R5 R6 random write mode", ddc_mode, e_mode);
      end else begin
        wbuf[0] = p;
        wr_txn(TGT, 1, ($urandom % 2) == 0);
        rd_txn(n, "R3 R7 R8 R9 random read");
      end
    end

    // R10: reset mid-run
    sysctl_write(8'h06, "R4 mode set before reset");
    rst_n = 1'b0; qw; rst_n = 1'b1; qw;
    e_ptr = 8'h00; e_req = 1'b0; e_mode = 1'b0;
    chk("R10 mode cleared by reset", ddc_mode, 0);
    rd_txn(28, "R10 pointer and request cleared by reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule